// File: doc/BRIEF.md
# Magnetic Flip-Flop Save and Restore Sequencer

This controller handles power gating for a region built from flip-flops that each keep a copy of their state in a complementary pair of magnetic tunnel junctions. When the rest of the system asks it to sleep, it writes the current latch value into the junction pair. The write happens in two heat-assisted phases, one junction per phase, and each phase ends with a cooling interval. Only after both phases does the controller open the supply switch of the region.

When the system asks it to wake, the controller closes the supply switch and waits for a settle interval it counts itself. It then pulses the reload strobe for a single cycle, so the latches sense the junction pair as a sense amplifier would. The controller then reports ready. The length of every phase is a parameter counted in clock cycles. The defaults give 20 ns for one heat-and-cool phase at a 5 ns clock, so a complete save takes 40 ns.

Two active-low lane controls, `ctl_a_no` and `ctl_b_no`, play both roles:
- In phase A, lane B opens the access path and lane A sources the heating current through junction A.
- Phase B swaps the two roles.

Top module: `nv_save_seq`

## Requirements
- R1: During reset and in the cycle after it: `ready_o`=1, `busy_o`=0, `supply_on_o`=1, `ctl_a_no`=`ctl_b_no`=1, `field_en_o`=0, `field_pol_o`=0, `reload_o`=0.
- R2: When `sleep_req_i` is sampled high while idle and powered, the controller enters phase A on the next cycle. Phase A runs in this order:
  - 1 cycle with only `ctl_b_no` low;
  - HEAT_CYC cycles with both lanes low;
  - FIELD_CYC cycles with both lanes low and `field_en_o`=1;
  - COOL_CYC cycles with both lanes high.
- R3: `field_en_o` is high only while both lane controls are low, and the cycle before it rises has both lanes low with the field off.
- R4: Phase B follows phase A directly, with the same durations and the lane roles swapped: `ctl_a_no` alone selects, and `ctl_b_no` joins it to heat.
- R5: `latch_d_i` is sampled in the cycle the sleep request is accepted. `field_pol_o` equals that value during the field cycles of phase A and its inverse during those of phase B. It is 0 whenever `field_en_o` is 0.
- R6: `supply_on_o` goes low only in the cycle after phase B's last cooling cycle. While it is low, both lanes are high and the field is off.
- R7: A wake request sampled while off sets `supply_on_o` high on the next cycle. SETTLE_CYC cycles follow with `reload_o` low, then one cycle with `reload_o` high, then `ready_o` rises.
- R8: A wake request sampled at any point during the save is held. The off state then lasts exactly one cycle and restore begins without a further request.
- R9: These requests are dropped, not stored:
  - a sleep request during restore;
  - a wake request while idle and powered;
  - a sleep request while off.
- R10: `busy_o` is high exactly when the controller is neither idle-powered nor off. `ready_o` is high only when idle and powered.
- R11: `reload_o` is a single-cycle pulse issued only with the supply on and both lanes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Request to save state and power down |
| wake_req_i | input | 1 | Request to power up and restore |
| latch_d_i | input | 1 | Current latch value, sampled at save start |
| ctl_a_no | output | 1 | Lane A control, active low |
| ctl_b_no | output | 1 | Lane B control, active low |
| field_en_o | output | 1 | Write-field current enable |
| field_pol_o | output | 1 | Write-field direction |
| reload_o | output | 1 | Reload strobe into the latches |
| supply_on_o | output | 1 | Supply switch closed when high |
| ready_o | output | 1 | Region powered and usable |
| busy_o | output | 1 | Sequence in progress |

## Verification
Every cycle, the assertions check the local safety rules:
- the field is on only while a junction is heated;
- the field is on only after a heated cycle;
- the supply is off only with both lanes inactive;
- the reload strobe lasts one cycle and has the supply and both lanes idle around it;
- busy and ready are never high together.

Only the bench's scenarios can show the ordering and timing properties:
- exact phase lengths;
- the swap of lane roles in phase B;
- polarity tied to the sampled latch value;
- the held wake request that cuts the off state to one cycle;
- the requests that are dropped.

The bench compares every output on every cycle against a cycle model derived from the requirements.

// File: rtl/nvbr_pkg.sv
`timescale 1ns/1ps
package nvbr_pkg;
  typedef enum logic [2:0] {
    ST_ON     = 3'd0,
    ST_SEL    = 3'd1,
    ST_HEAT   = 3'd2,
    ST_FIELD  = 3'd3,
    ST_COOL   = 3'd4,
    ST_OFF    = 3'd5,
    ST_SETTLE = 3'd6,
    ST_RELOAD = 3'd7
  } nvbr_state_e;
endpackage

// File: rtl/nvbr_timer.sv
`timescale 1ns/1ps
module nvbr_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - CW'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/nvbr_ctrl.sv
`timescale 1ns/1ps
module nvbr_ctrl
  import nvbr_pkg::*;
#(
  parameter int unsigned HEAT_CYC   = 1,
  parameter int unsigned FIELD_CYC  = 1,
  parameter int unsigned COOL_CYC   = 1,
  parameter int unsigned SETTLE_CYC = 3,
  parameter int unsigned CW         = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sleep_req_i,
  input  logic        wake_req_i,
  input  logic        latch_d_i,
  output nvbr_state_e state_o,
  output logic        phase_b_o,
  output logic        pol_o
);
  nvbr_state_e   st_q, st_d;
  logic          ph_q, ph_d;
  logic          pol_q, pend_q;
  logic          ld;
  logic [CW-1:0] len;
  logic          done;
  logic          saving;

  nvbr_timer #(.CW(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .len_i  (len),
    .done_o (done)
  );

  assign saving = (st_q == ST_SEL) || (st_q == ST_HEAT) ||
                  (st_q == ST_FIELD) || (st_q == ST_COOL);

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    ld   = 1'b0;
    len  = CW'(1);
    unique case (st_q)
      ST_ON: if (sleep_req_i) begin
        st_d = ST_SEL; ph_d = 1'b0; ld = 1'b1; len = CW'(1);
      end
      ST_SEL: if (done) begin
        st_d = ST_HEAT; ld = 1'b1; len = CW'(HEAT_CYC);
      end
      ST_HEAT: if (done) begin
        st_d = ST_FIELD; ld = 1'b1; len = CW'(FIELD_CYC);
      end
      ST_FIELD: if (done) begin
        st_d = ST_COOL; ld = 1'b1; len = CW'(COOL_CYC);
      end
      ST_COOL: if (done) begin
        if (!ph_q) begin
          st_d = ST_SEL; ph_d = 1'b1; ld = 1'b1; len = CW'(1);
        end else begin
          st_d = ST_OFF;
        end
      end
      ST_OFF: if (pend_q || wake_req_i) begin
        st_d = ST_SETTLE; ld = 1'b1; len = CW'(SETTLE_CYC);
      end
      ST_SETTLE: if (done) begin
        st_d = ST_RELOAD; ld = 1'b1; len = CW'(1);
      end
      ST_RELOAD: if (done) st_d = ST_ON;
      default: st_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ON;
      ph_q   <= 1'b0;
      pol_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      if (st_q == ST_ON && sleep_req_i) pol_q <= latch_d_i;
      // wake during save is parked until the off step
      if (st_q == ST_OFF)                pend_q <= 1'b0;
      else if (saving && wake_req_i)     pend_q <= 1'b1;
    end
  end

  assign state_o   = st_q;
  assign phase_b_o = ph_q;
  assign pol_o     = pol_q;
endmodule

// File: rtl/nvbr_decode.sv
`timescale 1ns/1ps
module nvbr_decode
  import nvbr_pkg::*;
(
  input  nvbr_state_e state_i,
  input  logic        phase_b_i,
  input  logic        pol_i,
  output logic        ctl_a_no,
  output logic        ctl_b_no,
  output logic        field_en_o,
  output logic        field_pol_o,
  output logic        reload_o,
  output logic        supply_on_o,
  output logic        ready_o,
  output logic        busy_o
);
  logic access, heating;

  always_comb begin
    access      = (state_i == ST_SEL) || (state_i == ST_HEAT) || (state_i == ST_FIELD);
    heating     = (state_i == ST_HEAT) || (state_i == ST_FIELD);
    // phase A: lane B selects, lane A heats; phase B swaps
    ctl_a_no    = !(phase_b_i ? access : heating);
    ctl_b_no    = !(phase_b_i ? heating : access);
    field_en_o  = (state_i == ST_FIELD);
    field_pol_o = field_en_o & (pol_i ^ phase_b_i);
    reload_o    = (state_i == ST_RELOAD);
    supply_on_o = (state_i != ST_OFF);
    ready_o     = (state_i == ST_ON);
    busy_o      = !((state_i == ST_ON) || (state_i == ST_OFF));
  end
endmodule

// File: rtl/nv_save_seq.sv
`timescale 1ns/1ps
module nv_save_seq
  import nvbr_pkg::*;
#(
  parameter int unsigned HEAT_CYC   = 1,
  parameter int unsigned FIELD_CYC  = 1,
  parameter int unsigned COOL_CYC   = 1,
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic latch_d_i,
  output logic ctl_a_no,
  output logic ctl_b_no,
  output logic field_en_o,
  output logic field_pol_o,
  output logic reload_o,
  output logic supply_on_o,
  output logic ready_o,
  output logic busy_o
);
  localparam int unsigned MAX_HF  = (HEAT_CYC > FIELD_CYC) ? HEAT_CYC : FIELD_CYC;
  localparam int unsigned MAX_CS  = (COOL_CYC > SETTLE_CYC) ? COOL_CYC : SETTLE_CYC;
  localparam int unsigned MAX_LEN = (MAX_HF > MAX_CS) ? MAX_HF : MAX_CS;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  nvbr_state_e st;
  logic        ph_b, pol;

  nvbr_ctrl #(
    .HEAT_CYC  (HEAT_CYC),
    .FIELD_CYC (FIELD_CYC),
    .COOL_CYC  (COOL_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .CW        (CW)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req_i),
    .wake_req_i (wake_req_i),
    .latch_d_i  (latch_d_i),
    .state_o    (st),
    .phase_b_o  (ph_b),
    .pol_o      (pol)
  );

  nvbr_decode i_decode (
    .state_i    (st),
    .phase_b_i  (ph_b),
    .pol_i      (pol),
    .ctl_a_no   (ctl_a_no),
    .ctl_b_no   (ctl_b_no),
    .field_en_o (field_en_o),
    .field_pol_o(field_pol_o),
    .reload_o   (reload_o),
    .supply_on_o(supply_on_o),
    .ready_o    (ready_o),
    .busy_o     (busy_o)
  );
endmodule

// File: rtl/nv_save_seq_chk.sv
`timescale 1ns/1ps
module nv_save_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ctl_a_no,
  input logic ctl_b_no,
  input logic field_en_o,
  input logic field_pol_o,
  input logic reload_o,
  input logic supply_on_o,
  input logic ready_o,
  input logic busy_o
);
  assert_field_heated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_en_o |-> (!ctl_a_no && !ctl_b_no));

  assert_heat_before_field_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(field_en_o) |-> $past(!ctl_a_no && !ctl_b_no));

  assert_pol_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_en_o |-> !field_pol_o);

  assert_off_idle_lanes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_on_o |-> (ctl_a_no && ctl_b_no && !field_en_o && !busy_o));

  assert_off_after_cool_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(supply_on_o) |-> $past(ctl_a_no && ctl_b_no && !field_en_o));

  assert_reload_safe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> (supply_on_o && ctl_a_no && ctl_b_no));

  assert_reload_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> !reload_o);

  assert_ready_after_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> ready_o);

  assert_ready_not_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && busy_o));
endmodule

bind nv_save_seq nv_save_seq_chk i_nv_save_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctl_a_no   (ctl_a_no),
  .ctl_b_no   (ctl_b_no),
  .field_en_o (field_en_o),
  .field_pol_o(field_pol_o),
  .reload_o   (reload_o),
  .supply_on_o(supply_on_o),
  .ready_o    (ready_o),
  .busy_o     (busy_o)
);

// File: tb/test_nv_save_seq.sv
`timescale 1ns/1ps
module test_nv_save_seq;
  localparam int H = 2, F = 2, C = 3, S = 4;
  localparam int L = 1 + H + F + C;
  localparam int M_ON = 0, M_SAVE = 1, M_OFF = 2, M_SET = 3, M_REL = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sleep_i = 1'b0, wake_i = 1'b0, data_i = 1'b0;
  logic ctl_a_no, ctl_b_no, field_en, field_pol, reload, supply_on, ready, busy;

  int n_tests = 0, n_fail = 0;
  bit fin = 1'b0;

  int mst = M_ON, k = 0, n = 0;
  bit mpend = 0, mpol = 0, held = 0, ign = 0;

  always #2.5 clk = ~clk;

  nv_save_seq #(.HEAT_CYC(H), .FIELD_CYC(F), .COOL_CYC(C), .SETTLE_CYC(S)) i_nv_save_seq (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_i), .wake_req_i(wake_i),
    .latch_d_i(data_i), .ctl_a_no(ctl_a_no), .ctl_b_no(ctl_b_no),
    .field_en_o(field_en), .field_pol_o(field_pol), .reload_o(reload),
    .supply_on_o(supply_on), .ready_o(ready), .busy_o(busy));

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    bit acc, heat, fe, pb;
    int j;
    string lt, pt;
    acc = 0; heat = 0; fe = 0; pb = 0;
    if (mst == M_SAVE) begin
      pb   = (k >= L);
      j    = k % L;
      acc  = (j < 1 + H + F);
      heat = (j >= 1) && (j < 1 + H + F);
      fe   = (j >= 1 + H) && (j < 1 + H + F);
    end
    lt = (mst == M_SAVE) ? (pb ? "R4" : "R2") : (ign ? "R9" : "R2");
    pt = (mst == M_OFF) ? "R6" : (held ? "R8" : "R7");
    chk(lt, "ctl_a_no", ctl_a_no, !(pb ? acc : heat));
    chk(lt, "ctl_b_no", ctl_b_no, !(pb ? heat : acc));
    chk("R3", "field_en", field_en, fe);
    chk("R5", "field_pol", field_pol, fe & (mpol ^ pb));
    chk(pt, "supply_on", supply_on, mst != M_OFF);
    chk("R11", "reload", reload, mst == M_REL);
    chk(ign ? "R9" : "R10", "ready", ready, mst == M_ON);
    chk("R10", "busy", busy, (mst == M_SAVE) || (mst == M_SET) || (mst == M_REL));
  endtask

  task automatic model_update(input bit s, input bit w, input bit d);
    case (mst)
      M_ON: if (s) begin mst = M_SAVE; k = 0; mpol = d; ign = 0; held = 0; end
      M_SAVE: begin
        if (w) mpend = 1;
        k++;
        if (k == 2 * L) mst = M_OFF;
      end
      M_OFF: begin
        if (mpend || w) begin mst = M_SET; n = 0; held = mpend; end
        mpend = 0;
      end
      M_SET: begin
        if (s) ign = 1;
        n++;
        if (n == S) mst = M_REL;
      end
      default: begin
        if (s) ign = 1;
        mst = M_ON;
      end
    endcase
  endtask

  task automatic step(input bit s, input bit w, input bit d);
    @(negedge clk);
    check_outs();
    sleep_i = s; wake_i = w; data_i = d;
    model_update(s, w, d);
    @(posedge clk);
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R7: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, during and after reset
    repeat (2) @(negedge clk);
    chk("R1", "ready", ready, 1'b1);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "supply_on", supply_on, 1'b1);
    chk("R1", "ctl_a_no", ctl_a_no, 1'b1);
    chk("R1", "ctl_b_no", ctl_b_no, 1'b1);
    chk("R1", "field_en", field_en, 1'b0);
    chk("R1", "field_pol", field_pol, 1'b0);
    chk("R1", "reload", reload, 1'b0);
    rst_ni = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "ready_after", ready, 1'b1);
    chk("R1", "reload_after", reload, 1'b0);

    // full save with d=1, then wake while off; R9 wake while on ignored first
    step(0, 1, 0); idle(2);
    step(1, 0, 1); idle(2 * L + 3);
    step(1, 0, 0); idle(2);           // R9 sleep while off
    step(0, 1, 0); idle(S + 4);

    // R8 wake during phase A, d=0
    step(1, 0, 0); idle(3); step(0, 1, 0); idle(2 * L + S + 6);

    // R8 wake in last cooling cycle
    step(1, 0, 1); idle(2 * L - 1); step(0, 1, 1); idle(S + 6);

    // R9 sleep during settle and reload
    step(1, 1, 1); idle(2 * L + 2); step(0, 1, 0);
    step(1, 0, 0); idle(S - 2); step(1, 0, 0); step(1, 0, 1); idle(4);

    // random mix
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4000; i++)
      step(($urandom % 8) == 0, ($urandom % 8) == 0, $urandom % 2);
    idle(2 * L + S + 4);

    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule